// File: doc/BRIEF.md
# Panel Power-Up and Configuration Sequencer

This block brings a small TFT display controller from cold power to a configured, running state. After a start command it holds the panel's reset line asserted, turns on the supply enable, waits a fixed number of milliseconds, releases reset, and waits again before the first register access. It then reads the identification register and checks the returned value. If the value matches, it writes an ordered set of configuration registers through a simple request/acknowledge port that feeds an external serial master.

The settings arrive as plain inputs in physical terms: regulator voltage in millivolts, two common-electrode levels in percent, gamma correction values, signal polarities, sync mode, input format and image flips. The block converts them into register codes itself. A voltage input of zero means the hardware default is kept, and its write is left out. Once configured, separate commands place the panel in normal mode or in standby. Time comes from an external tick input, and a parameter sets the number of ticks per millisecond. The configuration inputs must be held stable while `busy_o` is high.

Top module: `pnl_pwr_seq`

## Requirements
- R1: After reset `panel_rst_o`=1 and `supply_en_o`=0. An accepted start raises `supply_en_o` while `panel_rst_o` stays 1. `panel_rst_o` falls after exactly HOLD_MS*TICKS_PER_MS ticks have been seen in that state. The first request is issued after exactly SETTLE_MS*TICKS_PER_MS further ticks. No request is made while reset is asserted or the supply is off.
- R2: The first access is a read (`req_wr_o`=0) of address 0x00. A returned value other than 0x96 ends the sequence with `err_o`=1, `busy_o`=0 and no writes.
- R3: After a good identification the writes go out in this order: 0x00 to address 0x04; the regulator code to 0x03; the amplitude code to 0x01; the high-level code to 0x02; gamma bytes to 0x10 through 0x17; polarity to 0x0A; interface control to 0x0B; entry to 0x06. Then `ready_o`=1.
- R4: Regulator code = (mV-3600)/100. Accepted values are 3600 to 6000 in steps of 100.
- R5: High-level code = percent-37. Accepted values are 37 to 100.
- R6: Amplitude code = (percent-70)>>1. Accepted values are 70 to 132.
- R7: A voltage input of zero drops that register's write. The remaining order is unchanged.
- R8: Gamma byte k holds the negative value k in bits 7:4 and the positive value k in bits 3:0. Each value above 15 is written as 15.
- R9: The polarity byte is bit0=data clock rising, bit1=hsync high, bit2=vsync high, bit3=data-enable high. Bits 7:4 are 0.
- R10: Interface control = sync_mode*4 + 1. Entry = in_fmt*16 + 0xC, plus 2 when the image is not flipped vertically and 1 when it is not flipped horizontally.
- R11: In the ready state, an enable command writes 0xEF to address 0x07 and a disable command writes 0xEE there. If both arrive in the same cycle, the disable wins.
- R12: An out-of-range voltage input at start sets `err_o` on the next cycle. The supply stays off and no request is made.
- R13: `busy_o` is high from the cycle after an accepted start, or after a command, until the cycle after the final acknowledge. Start, enable and disable have no effect while busy. Start is accepted only when idle or in error. Enable and disable are accepted only when ready.
- R14: A request keeps `req_o`, `req_wr_o`, `req_addr_o` and `req_wdata_o` stable until `ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base pulse, TICKS_PER_MS per millisecond |
| start_i | input | 1 | Begin power-up and configuration |
| enable_i | input | 1 | Switch the panel to normal mode |
| disable_i | input | 1 | Switch the panel to standby |
| vreg_mv_i | input | 13 | Regulator voltage in mV, 0 = keep default |
| vcom_hi_pct_i | input | 8 | Common high level in percent, 0 = keep default |
| vcom_amp_pct_i | input | 8 | Common amplitude in percent, 0 = keep default |
| gam_neg_i | input | GAM_N*GIN_W | Negative gamma values, entry k at [k*GIN_W +: GIN_W] |
| gam_pos_i | input | GAM_N*GIN_W | Positive gamma values, same layout |
| dclk_rise_i | input | 1 | Data is sampled on the rising clock edge |
| de_high_i | input | 1 | Data enable is active high |
| hs_high_i | input | 1 | Horizontal sync is active high |
| vs_high_i | input | 1 | Vertical sync is active high |
| sync_mode_i | input | 2 | Sync signalling mode |
| in_fmt_i | input | 4 | Input stream format code |
| flip_h_i | input | 1 | Mirror the image horizontally |
| flip_v_i | input | 1 | Mirror the image vertically |
| panel_rst_o | output | 1 | Panel reset, 1 = asserted |
| supply_en_o | output | 1 | Panel supply enable |
| req_o | output | 1 | Register access request |
| req_wr_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 8 | Register address |
| req_wdata_o | output | 8 | Write data |
| ack_i | input | 1 | Access complete, one-cycle pulse |
| rdata_i | input | 8 | Read data, valid with ack_i |
| busy_o | output | 1 | Sequence or command in progress |
| ready_o | output | 1 | Configured and accepting commands |
| err_o | output | 1 | Stopped on a bad setting or a wrong identification |

## Verification
The bench drives inputs and samples outputs on falling clock edges. `busy_o` and `err_o` are checked at the first falling edge after the start pulse's rising edge, because they are registered one cycle after it. Each request is checked against a queue of expected accesses built from R3 to R11, at the falling edge where the bench's responder accepts it. The next request, and the drop of `busy_o` after the last acknowledge, are due one cycle after the acknowledge edge and are checked at the falling edge that follows. Ticks are counted against the reset and supply levels seen in the same cycle, so the two waits are checked to the exact tick.

// File: rtl/pnl_seq_pkg.sv
package pnl_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_RST, ST_ID, ST_CFG, ST_RDY, ST_CMD, ST_ERR
  } seq_st_e;

  localparam logic [7:0] ADR_ID    = 8'h00;
  localparam logic [7:0] ADR_GRST  = 8'h04;
  localparam logic [7:0] ADR_VREG  = 8'h03;
  localparam logic [7:0] ADR_VAMP  = 8'h01;
  localparam logic [7:0] ADR_VHI   = 8'h02;
  localparam logic [7:0] ADR_GAM0  = 8'h10;
  localparam logic [7:0] ADR_POL   = 8'h0A;
  localparam logic [7:0] ADR_IFC   = 8'h0B;
  localparam logic [7:0] ADR_ENT   = 8'h06;
  localparam logic [7:0] ADR_PWR   = 8'h07;
  localparam logic [7:0] PWR_RUN   = 8'hEF;
  localparam logic [7:0] PWR_STBY  = 8'hEE;

endpackage

// File: rtl/pnl_code_conv.sv
module pnl_code_conv #(
  parameter int GAM_N = 8,
  parameter int GIN_W = 8
) (
  input  logic [12:0]            vreg_mv_i,
  input  logic [7:0]             vhi_pct_i,
  input  logic [7:0]             vamp_pct_i,
  input  logic [GAM_N*GIN_W-1:0] gam_neg_i,
  input  logic [GAM_N*GIN_W-1:0] gam_pos_i,
  input  logic                   dclk_rise_i,
  input  logic                   de_high_i,
  input  logic                   hs_high_i,
  input  logic                   vs_high_i,
  input  logic [1:0]             sync_i,
  input  logic [3:0]             fmt_i,
  input  logic                   flip_h_i,
  input  logic                   flip_v_i,
  output logic [7:0]             vreg_code_o,
  output logic [7:0]             vhi_code_o,
  output logic [7:0]             vamp_code_o,
  output logic                   vreg_skip_o,
  output logic                   vhi_skip_o,
  output logic                   vamp_skip_o,
  output logic [GAM_N-1:0][7:0]  gam_o,
  output logic [7:0]             pol_o,
  output logic [7:0]             ifc_o,
  output logic [7:0]             ent_o,
  output logic                   cfg_ok_o
);

  logic [12:0] mv_off;
  logic [12:0] mv_div;
  logic [7:0]  amp_off;
  logic        vreg_ok, vhi_ok, vamp_ok;

  assign mv_off = vreg_mv_i - 13'd3600;
  assign mv_div = mv_off / 13'd100;
  assign amp_off = vamp_pct_i - 8'd70;

  assign vreg_code_o = mv_div[7:0];
  assign vhi_code_o  = vhi_pct_i - 8'd37;
  assign vamp_code_o = {1'b0, amp_off[7:1]};

  assign vreg_skip_o = (vreg_mv_i == '0);
  assign vhi_skip_o  = (vhi_pct_i == '0);
  assign vamp_skip_o = (vamp_pct_i == '0);

  assign vreg_ok = vreg_skip_o ||
                   (vreg_mv_i >= 13'd3600 && vreg_mv_i <= 13'd6000 &&
                    (mv_off % 13'd100) == '0);
  assign vhi_ok  = vhi_skip_o || (vhi_pct_i >= 8'd37 && vhi_pct_i <= 8'd100);
  assign vamp_ok = vamp_skip_o || (vamp_pct_i >= 8'd70 && vamp_pct_i <= 8'd132);
  assign cfg_ok_o = vreg_ok && vhi_ok && vamp_ok;

  function automatic logic [3:0] sat4(input logic [GIN_W-1:0] v);
    return (v > GIN_W'(15)) ? 4'hF : v[3:0];
  endfunction

  for (genvar g = 0; g < GAM_N; g++) begin : g_gam
    assign gam_o[g] = {sat4(gam_neg_i[g*GIN_W +: GIN_W]),
                       sat4(gam_pos_i[g*GIN_W +: GIN_W])};
  end

  assign pol_o = {4'b0000, de_high_i, vs_high_i, hs_high_i, dclk_rise_i};
  assign ifc_o = {4'b0000, sync_i, 2'b01};
  assign ent_o = {fmt_i, 2'b11, ~flip_v_i, ~flip_h_i};

endmodule

// File: rtl/pnl_tick_timer.sv
module pnl_tick_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // final tick of the window
  assign last_o = tick_i && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq
  import pnl_seq_pkg::*;
#(
  parameter int         TICKS_PER_MS = 1000,
  parameter int         HOLD_MS      = 20,
  parameter int         SETTLE_MS    = 10,
  parameter int         GAM_N        = 8,
  parameter int         GIN_W        = 8,
  parameter logic [7:0] CHIP_ID      = 8'h96
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   start_i,
  input  logic                   enable_i,
  input  logic                   disable_i,
  input  logic [12:0]            vreg_mv_i,
  input  logic [7:0]             vcom_hi_pct_i,
  input  logic [7:0]             vcom_amp_pct_i,
  input  logic [GAM_N*GIN_W-1:0] gam_neg_i,
  input  logic [GAM_N*GIN_W-1:0] gam_pos_i,
  input  logic                   dclk_rise_i,
  input  logic                   de_high_i,
  input  logic                   hs_high_i,
  input  logic                   vs_high_i,
  input  logic [1:0]             sync_mode_i,
  input  logic [3:0]             in_fmt_i,
  input  logic                   flip_h_i,
  input  logic                   flip_v_i,
  output logic                   panel_rst_o,
  output logic                   supply_en_o,
  output logic                   req_o,
  output logic                   req_wr_o,
  output logic [7:0]             req_addr_o,
  output logic [7:0]             req_wdata_o,
  input  logic                   ack_i,
  input  logic [7:0]             rdata_i,
  output logic                   busy_o,
  output logic                   ready_o,
  output logic                   err_o
);

  localparam int HOLD_T   = HOLD_MS * TICKS_PER_MS;
  localparam int SETTLE_T = SETTLE_MS * TICKS_PER_MS;
  localparam int MAX_T    = (HOLD_T > SETTLE_T) ? HOLD_T : SETTLE_T;
  localparam int CNT_W    = $clog2(MAX_T + 1);
  localparam int N_STEP   = 7 + GAM_N;
  localparam int STEP_W   = $clog2(N_STEP);
  localparam int GSEL_W   = (GAM_N > 1) ? $clog2(GAM_N) : 1;
  localparam int ST_GAM   = 4;
  localparam int ST_POL   = ST_GAM + GAM_N;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEP - 1);

  seq_st_e           st_q;
  logic [STEP_W-1:0] step_q;
  logic              cmd_run_q;
  logic              supply_q, prst_q;

  logic [7:0]            vreg_code, vhi_code, vamp_code, pol_b, ifc_b, ent_b;
  logic                  vreg_skip, vhi_skip, vamp_skip, cfg_ok;
  logic [GAM_N-1:0][7:0] gam_b;

  pnl_code_conv #(.GAM_N(GAM_N), .GIN_W(GIN_W)) u_conv (
    .vreg_mv_i   (vreg_mv_i),
    .vhi_pct_i   (vcom_hi_pct_i),
    .vamp_pct_i  (vcom_amp_pct_i),
    .gam_neg_i   (gam_neg_i),
    .gam_pos_i   (gam_pos_i),
    .dclk_rise_i (dclk_rise_i),
    .de_high_i   (de_high_i),
    .hs_high_i   (hs_high_i),
    .vs_high_i   (vs_high_i),
    .sync_i      (sync_mode_i),
    .fmt_i       (in_fmt_i),
    .flip_h_i    (flip_h_i),
    .flip_v_i    (flip_v_i),
    .vreg_code_o (vreg_code),
    .vhi_code_o  (vhi_code),
    .vamp_code_o (vamp_code),
    .vreg_skip_o (vreg_skip),
    .vhi_skip_o  (vhi_skip),
    .vamp_skip_o (vamp_skip),
    .gam_o       (gam_b),
    .pol_o       (pol_b),
    .ifc_o       (ifc_b),
    .ent_o       (ent_b),
    .cfg_ok_o    (cfg_ok)
  );

  logic             start_ok, t_load, t_last;
  logic [CNT_W-1:0] t_val;

  assign start_ok = (st_q == ST_IDLE || st_q == ST_ERR) && start_i;
  assign t_load   = (start_ok && cfg_ok) || (st_q == ST_PWR && t_last);
  assign t_val    = (st_q == ST_PWR) ? CNT_W'(SETTLE_T) : CNT_W'(HOLD_T);

  pnl_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .tick_i     (tick_i),
    .last_o     (t_last)
  );

  // step decode for the configuration list
  logic [7:0]        cfg_addr, cfg_data;
  logic              cfg_skip;
  logic [STEP_W-1:0] gsel_full;
  logic [GSEL_W-1:0] gsel;

  assign gsel_full = step_q - STEP_W'(ST_GAM);
  assign gsel      = gsel_full[GSEL_W-1:0];

  always_comb begin
    cfg_addr = ADR_ENT;
    cfg_data = ent_b;
    cfg_skip = 1'b0;
    if (step_q == STEP_W'(0)) begin
      cfg_addr = ADR_GRST; cfg_data = 8'h00;
    end else if (step_q == STEP_W'(1)) begin
      cfg_addr = ADR_VREG; cfg_data = vreg_code; cfg_skip = vreg_skip;
    end else if (step_q == STEP_W'(2)) begin
      cfg_addr = ADR_VAMP; cfg_data = vamp_code; cfg_skip = vamp_skip;
    end else if (step_q == STEP_W'(3)) begin
      cfg_addr = ADR_VHI;  cfg_data = vhi_code;  cfg_skip = vhi_skip;
    end else if (step_q < STEP_W'(ST_POL)) begin
      cfg_addr = ADR_GAM0 + 8'(gsel); cfg_data = gam_b[gsel];
    end else if (step_q == STEP_W'(ST_POL)) begin
      cfg_addr = ADR_POL;  cfg_data = pol_b;
    end else if (step_q == STEP_W'(ST_POL + 1)) begin
      cfg_addr = ADR_IFC;  cfg_data = ifc_b;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      step_q    <= '0;
      cmd_run_q <= 1'b0;
      supply_q  <= 1'b0;
      prst_q    <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_ERR: if (start_ok) begin
          if (cfg_ok) begin
            st_q     <= ST_PWR;
            supply_q <= 1'b1;
            prst_q   <= 1'b1;
          end else begin
            st_q <= ST_ERR;
          end
        end
        ST_PWR: if (t_last) begin
          st_q   <= ST_RST;
          prst_q <= 1'b0;
        end
        ST_RST: if (t_last) st_q <= ST_ID;
        ST_ID: if (ack_i) begin
          st_q   <= (rdata_i == CHIP_ID) ? ST_CFG : ST_ERR;
          step_q <= '0;
        end
        ST_CFG: if (ack_i || cfg_skip) begin
          if (step_q == LAST_STEP) st_q <= ST_RDY;
          else                     step_q <= step_q + 1'b1;
        end
        ST_RDY: if (disable_i) begin
          st_q <= ST_CMD; cmd_run_q <= 1'b0;
        end else if (enable_i) begin
          st_q <= ST_CMD; cmd_run_q <= 1'b1;
        end
        ST_CMD: if (ack_i) st_q <= ST_RDY;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_o       = 1'b0;
    req_wr_o    = 1'b1;
    req_addr_o  = cfg_addr;
    req_wdata_o = cfg_data;
    unique case (st_q)
      ST_ID: begin
        req_o = 1'b1; req_wr_o = 1'b0; req_addr_o = ADR_ID; req_wdata_o = 8'h00;
      end
      ST_CFG: req_o = !cfg_skip;
      ST_CMD: begin
        req_o = 1'b1; req_addr_o = ADR_PWR;
        req_wdata_o = cmd_run_q ? PWR_RUN : PWR_STBY;
      end
      default: ;
    endcase
  end

  assign panel_rst_o = prst_q;
  assign supply_en_o = supply_q;
  assign busy_o  = (st_q == ST_PWR) || (st_q == ST_RST) || (st_q == ST_ID) ||
                   (st_q == ST_CFG) || (st_q == ST_CMD);
  assign ready_o = (st_q == ST_RDY);
  assign err_o   = (st_q == ST_ERR);

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(req_wr_o) && $stable(req_addr_o) &&
                        $stable(req_wdata_o)); // R14
  AST_SUPPLY_UNDER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supply_en_o) |-> panel_rst_o); // R1
  AST_NO_ACCESS_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> supply_en_o && !panel_rst_o); // R1
  AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !req_o); // R12
  AST_BUSY_ENDS_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ready_o || err_o); // R13
  AST_CFG_WRITE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CFG) |-> cfg_ok); // R12

endmodule

// File: tb/sim_pnl_pwr_seq.sv
module sim_pnl_pwr_seq;

  localparam int TPMS = 3;
  localparam int LAT  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_ni = 1'b0, tick_i = 1'b0, start_i = 1'b0;
  logic        enable_i = 1'b0, disable_i = 1'b0;
  logic [12:0] vreg_mv = '0;
  logic [7:0]  vhi = '0, vamp = '0;
  logic [63:0] gneg = '0, gpos = '0;
  logic        dclk_r = 1'b0, de_h = 1'b0, hs_h = 1'b0, vs_h = 1'b0;
  logic [1:0]  sync_m = '0;
  logic [3:0]  fmt = '0;
  logic        fh = 1'b0, fv = 1'b0;
  logic        panel_rst_o, supply_en_o, req_o, req_wr_o, busy_o, ready_o, err_o;
  logic [7:0]  req_addr_o, req_wdata_o;
  logic        ack_i = 1'b0;
  logic [7:0]  rdata_i = '0;

  pnl_pwr_seq #(.TICKS_PER_MS(TPMS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .start_i(start_i),
    .enable_i(enable_i), .disable_i(disable_i), .vreg_mv_i(vreg_mv),
    .vcom_hi_pct_i(vhi), .vcom_amp_pct_i(vamp), .gam_neg_i(gneg), .gam_pos_i(gpos),
    .dclk_rise_i(dclk_r), .de_high_i(de_h), .hs_high_i(hs_h), .vs_high_i(vs_h),
    .sync_mode_i(sync_m), .in_fmt_i(fmt), .flip_h_i(fh), .flip_v_i(fv),
    .panel_rst_o(panel_rst_o), .supply_en_o(supply_en_o), .req_o(req_o),
    .req_wr_o(req_wr_o), .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
    .ack_i(ack_i), .rdata_i(rdata_i), .busy_o(busy_o), .ready_o(ready_o), .err_o(err_o)
  );

  int errs = 0, checks = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  id_val = 8'h96;
  int n_acc = 0, lat = 0, cyc = 0, ph_a = 0, ph_b = 0;
  bit pend_idle = 0, seen_req = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cap(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  // tick source and wait-phase tick counting
  always @(negedge clk) begin
    cyc++;
    tick_i = (cyc % 4 == 0);
    if (tick_i) begin
      if (supply_en_o && panel_rst_o) ph_a++;
      else if (supply_en_o && !panel_rst_o && !req_o && !seen_req) ph_b++;
    end
    if (req_o) seen_req = 1;
  end

  // serial-master stand-in, checks each access against the reference queue
  always @(negedge clk) begin
    if (!rst_ni) begin
      ack_i = 0; lat = 0; pend_idle = 0;
    end else if (ack_i) begin
      ack_i = 0;
      if (pend_idle) begin
        chk(!busy_o, "R13 busy low after final ack", busy_o, 0);
        pend_idle = 0;
      end
    end else if (req_o) begin
      if (lat == LAT) begin
        logic [16:0] got;
        lat = 0;
        got = {req_wr_o, req_addr_o, req_wr_o ? req_wdata_o : 8'h00};
        if (exp_q.size() == 0) chk(0, "R3/R13 unexpected access", int'(got), 0);
        else begin
          logic [16:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(got == e, t, int'(got), int'(e));
        end
        if (!req_wr_o) rdata_i = id_val;
        ack_i = 1;
        n_acc++;
        if (exp_q.size() == 0) pend_idle = 1;
      end else lat++;
    end
  end

  task automatic push(input bit wr, input int a, input int d, input string t);
    exp_q.push_back({wr, 8'(a), 8'(d)});
    tag_q.push_back(t);
  endtask

  task automatic set_gam(input int n[8], input int p[8]);
    for (int g = 0; g < 8; g++) begin
      gneg[g*8 +: 8] = 8'(n[g]);
      gpos[g*8 +: 8] = 8'(p[g]);
    end
  endtask

  task automatic build_expect();
    push(0, 8'h00, 0, "R2 identification read");
    push(1, 8'h04, 8'h00, "R3 global reset write");
    if (vreg_mv != 0) push(1, 8'h03, (int'(vreg_mv) - 3600) / 100, "R4 regulator code");
    if (vamp != 0)    push(1, 8'h01, (int'(vamp) - 70) / 2, "R6 amplitude code");
    if (vhi != 0)     push(1, 8'h02, int'(vhi) - 37, "R5 high-level code");
    for (int g = 0; g < 8; g++)
      push(1, 8'h10 + g, cap(int'(gneg[g*8 +: 8])) * 16 + cap(int'(gpos[g*8 +: 8])),
           "R8 gamma byte");
    push(1, 8'h0A, int'(dclk_r) + 2*int'(hs_h) + 4*int'(vs_h) + 8*int'(de_h), "R9 polarity");
    push(1, 8'h0B, int'(sync_m) * 4 + 1, "R10 interface control");
    push(1, 8'h06, int'(fmt) * 16 + 12 + (fv ? 0 : 2) + (fh ? 0 : 1), "R10 entry");
  endtask

  task automatic do_reset();
    rst_ni = 0;
    exp_q.delete(); tag_q.delete();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic pulse(input bit s, input bit en, input bit dis);
    start_i = s; enable_i = en; disable_i = dis;
    @(negedge clk);
    start_i = 0; enable_i = 0; disable_i = 0;
  endtask

  task automatic wait_idle(input string t);
    int n = 0;
    while (busy_o && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk(!busy_o, t, busy_o, 0);
  endtask

  task automatic run_cfg(input bit poke_busy);
    ph_a = 0; ph_b = 0; seen_req = 0; n_acc = 0;
    build_expect();
    pulse(1, 0, 0);
    chk(busy_o && !err_o, "R13 busy one cycle after start", busy_o, 1);
    chk(supply_en_o && panel_rst_o, "R1 supply on under reset", {supply_en_o, panel_rst_o}, 3);
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      pulse(1, 1, 1);
    end
    wait_idle("R13 sequence completes");
    chk(ready_o, "R3 ready after list", ready_o, 1);
    chk(ph_a == 20*TPMS, "R1 reset hold ticks", ph_a, 20*TPMS);
    chk(ph_b == 10*TPMS, "R1 settle ticks", ph_b, 10*TPMS);
    chk(exp_q.size() == 0, "R3 all writes issued", exp_q.size(), 0);
  endtask

  task automatic bad_cfg(input int mv, input int hi, input int amp, input string t);
    do_reset();
    vreg_mv = 13'(mv); vhi = 8'(hi); vamp = 8'(amp);
    n_acc = 0;
    pulse(1, 0, 0);
    chk(err_o && !busy_o, t, {err_o, busy_o}, 2);
    repeat (40) @(negedge clk);
    chk(!supply_en_o && n_acc == 0, "R12 no supply, no access", {supply_en_o, 8'(n_acc)}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int na;
    repeat (3) @(negedge clk);
    chk(panel_rst_o && !supply_en_o, "R1 reset state pins", {panel_rst_o, supply_en_o}, 2);
    chk(!busy_o && !ready_o && !err_o && !req_o, "R13 reset state flags",
        {busy_o, ready_o, err_o, req_o}, 0);
    rst_ni = 1;
    @(negedge clk);

    // run A: typical settings, one gamma value over range, commands poked while busy
    vreg_mv = 13'd4600; vhi = 8'd91; vamp = 8'd114;
    set_gam('{10, 5, 7, 7, 7, 5, 1, 6}, '{7, 7, 3, 2, 3, 5, 7, 20});
    dclk_r = 1; de_h = 0; hs_h = 1; vs_h = 0; sync_m = 2'd3; fmt = 4'hB; fh = 0; fv = 1;
    run_cfg(1);

    // commands from ready
    push(1, 8'h07, 8'hEF, "R11 enable writes run code");
    pulse(0, 1, 0);
    wait_idle("R11 enable completes");
    push(1, 8'h07, 8'hEE, "R11 disable writes standby code");
    pulse(0, 0, 1);
    wait_idle("R11 disable completes");
    push(1, 8'h07, 8'hEE, "R11 disable wins over enable");
    pulse(0, 1, 1);
    wait_idle("R11 dual command completes");
    chk(exp_q.size() == 0, "R11 commands issued", exp_q.size(), 0);
    na = n_acc;
    pulse(1, 0, 0);
    repeat (40) @(negedge clk);
    chk(ready_o && supply_en_o && !panel_rst_o && n_acc == na,
        "R13 start ignored when ready", n_acc, na);

    // run B: defaults kept, gamma saturated, all polarities set, both flips
    do_reset();
    vreg_mv = 0; vhi = 0; vamp = 0;
    set_gam('{16, 255, 15, 0, 31, 9, 200, 17}, '{100, 15, 16, 0, 1, 40, 12, 255});
    dclk_r = 1; de_h = 1; hs_h = 1; vs_h = 1; sync_m = 2'd0; fmt = 4'h5; fh = 1; fv = 1;
    run_cfg(0);
    chk(n_acc == 13, "R7 zero settings skipped", n_acc, 13);

    // run C and D: range edges
    do_reset();
    vreg_mv = 13'd3600; vhi = 8'd100; vamp = 8'd70;
    set_gam('{1, 2, 3, 4, 5, 6, 7, 8}, '{8, 7, 6, 5, 4, 3, 2, 1});
    dclk_r = 0; de_h = 1; hs_h = 0; vs_h = 1; sync_m = 2'd1; fmt = 4'h0; fh = 1; fv = 0;
    run_cfg(0);
    chk(n_acc == 16, "R4 R5 R6 low edges written", n_acc, 16);
    do_reset();
    vreg_mv = 13'd6000; vhi = 8'd37; vamp = 8'd132;
    sync_m = 2'd2; fmt = 4'h8; fh = 0; fv = 0;
    run_cfg(0);

    // run E: wrong identification
    do_reset();
    id_val = 8'h95;
    n_acc = 0;
    push(0, 8'h00, 0, "R2 identification read");
    pulse(1, 0, 0);
    wait_idle("R2 stop after bad id");
    chk(err_o && !ready_o, "R2 error on bad id", {err_o, ready_o}, 2);
    pulse(0, 1, 0);
    repeat (20) @(negedge clk);
    chk(n_acc == 1 && err_o, "R2 no writes after bad id", n_acc, 1);
    id_val = 8'h96;

    // run F: out-of-range settings
    bad_cfg(3500, 0, 0, "R12 regulator below range");
    bad_cfg(4650, 0, 0, "R12 regulator off step");
    bad_cfg(6100, 0, 0, "R12 regulator above range");
    bad_cfg(0, 101, 0, "R12 high level above range");
    bad_cfg(0, 36, 0, "R12 high level below range");
    bad_cfg(0, 0, 69, "R12 amplitude below range");
    bad_cfg(0, 0, 133, "R12 amplitude above range");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule